// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a down-counting interval timer that a processor programs through a small word-addressed register bus. A control word sets the tick rate, the behaviour at underflow, the interrupt enable and whether a new period value reaches the live counter at once. The counter steps once per prescaled tick. The tick is derived from half the core clock, divided again by a power of two that software chooses. When the counter steps past zero it either restarts from the programmed period or wraps to all ones and keeps running freely. The same event raises a sticky flag, and that flag drives a level interrupt.

Software reads the live count at any time. It clears the flag either by writing a one into the flag position of the control word or by writing a new period. A control write that only toggles the interrupt enable leaves the counter and its tick phase alone. Every other control write restarts the tick phase under the new settings.

Top module: `intv_timer`

## Requirements
- R1: After reset the control word reads 0x0000, the period and count registers read 0xFFFF, and `irq_o` is low.
- R2: Word offsets are fixed: 0x0 is the control word, 0x2 the period register, 0x4 the live count. Writes to offset 0x4 are ignored. Reads of any other offset return 0.
- R3: The control word keeps run in bit 0 and the prescaler code N in bits 11:8. While bit 0 is 1 the count steps once every 2^(N+1) clocks, with the first step 2^(N+1) clocks after the edge of the restarting write. While bit 0 is 0 the count holds.
- R4: With bit 1 (restart-from-period) set, a tick at count 0 loads the period register.
- R5: With bit 1 clear, a tick at count 0 loads 0xFFFF (free running).
- R6: The tick that leaves count 0 sets the flag (control bit 2) on the same edge. The flag stays set until software clears it.
- R7: A control write with a 1 in bit 2 clears the flag, and a 0 there leaves it. An underflow on the same edge wins.
- R8: `irq_o` is high exactly while the flag and the interrupt enable (bit 3) are both 1.
- R9: A control write that differs from the stored control bits only in bit 3 (and bit 2) keeps the count and the tick phase running undisturbed.
- R10: Any other control write resets the tick phase, so that the next step comes a full prescaled period after that write.
- R11: A period write clears the flag. With bit 4 (immediate load) set, it also loads the count on the same edge, and that load beats a tick. With bit 4 clear the count is untouched.
- R12: Bits 5 and 6 are stored and read back but do not affect counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 3 | Byte offset of the register word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt request |

## Verification
Register writes land on the clock edge that samples `bus_wr`. Read data and `irq_o` are combinational from state, so they reflect that write half a clock later. Count steps fall a whole multiple of 2^(N+1) edges after the restarting write. The bench counts edges from each write, drives reads on falling edges and compares them just after. This places every expected count exactly on or just past a step, an underflow or a phase-sensitive control write. Checks are placed on the edge where a restart would move a step and where an immediate load meets a tick, so that an off-by-one change there is seen at the ports.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int PRE_W  = 4;
  // phase counter must hold 2^(2^PRE_W) - 1
  localparam int PH_W   = (1 << PRE_W) + 1;

  // control word bit positions (software-visible layout)
  localparam int B_EN   = 0;
  localparam int B_RLD  = 1;
  localparam int B_FLAG = 2;
  localparam int B_IE   = 3;
  localparam int B_OVW  = 4;
  localparam int B_DBG  = 5;
  localparam int B_DOZE = 6;
  localparam int B_PRE  = 8;

  localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_MOD  = 3'd2;
  localparam logic [ADDR_W-1:0] OFF_CNT  = 3'd4;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic             doze;
    logic             dbg;
    logic             ovw;
    logic             ie;
    logic             rld;
    logic             en;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.en   = w[B_EN];
    c.rld  = w[B_RLD];
    c.ie   = w[B_IE];
    c.ovw  = w[B_OVW];
    c.dbg  = w[B_DBG];
    c.doze = w[B_DOZE];
    c.pre  = w[B_PRE +: PRE_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c, input logic flag);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_EN]   = c.en;
    w[B_RLD]  = c.rld;
    w[B_FLAG] = flag;
    w[B_IE]   = c.ie;
    w[B_OVW]  = c.ovw;
    w[B_DBG]  = c.dbg;
    w[B_DOZE] = c.doze;
    w[B_PRE +: PRE_W] = c.pre;
    return w;
  endfunction

  // true when two control settings agree on every bit except the enable of the interrupt
  function automatic logic only_ie_differs(input ctrl_t a, input ctrl_t b);
    ctrl_t x;
    ctrl_t y;
    x = a;
    y = b;
    x.ie = 1'b0;
    y.ie = 1'b0;
    return x == y;
  endfunction

  // last phase value before a tick: 2^(n+1) - 1
  function automatic logic [PH_W-1:0] tick_limit(input logic [PRE_W-1:0] n);
    return (PH_W'(1) << (32'(n) + 1)) - PH_W'(1);
  endfunction

endpackage

// File: rtl/intv_prescaler.sv
module intv_prescaler
  import intv_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] limit;

  assign limit = tick_limit(pre);
  assign tick  = run && (phase == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= '0;
    else if (!run || restart)   phase <= '0;
    else if (tick)              phase <= '0;
    else                        phase <= phase + PH_W'(1);
  end

  p_phase_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase == '0));

  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (phase <= limit));

  p_restart_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == '0));

endmodule

// File: rtl/intv_counter.sv
module intv_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             rld,
  input  logic [CNT_W-1:0] period,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             underflow
);

  logic [CNT_W-1:0] wrap_val;

  function automatic logic [CNT_W-1:0] next_wrap(input logic r, input logic [CNT_W-1:0] p);
    return r ? p : {CNT_W{1'b1}};
  endfunction

  assign wrap_val  = next_wrap(rld, period);
  assign underflow = tick && !load && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= {CNT_W{1'b1}};
    else if (load)       count <= load_val;
    else if (underflow)  count <= wrap_val;
    else if (tick)       count <= count - CNT_W'(1);
  end

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && count != '0) |=> (count == $past(count) - CNT_W'(1)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (count == $past(wrap_val)));

  p_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

endmodule

// File: rtl/intv_regs.sv
module intv_regs
  import intv_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              underflow,
  output ctrl_t             ctrl,
  output logic              flag,
  output logic [CNT_W-1:0]  period,
  output logic              restart,
  output logic              ovw_load
);

  logic  ctrl_wr;
  logic  mod_wr;
  logic  flag_clr;
  ctrl_t new_ctrl;

  assign ctrl_wr  = bus_wr && (bus_addr == OFF_CTRL);
  assign mod_wr   = bus_wr && (bus_addr == OFF_MOD);
  assign new_ctrl = ctrl_from_word(bus_wdata);
  assign restart  = ctrl_wr && !only_ie_differs(ctrl, new_ctrl);
  assign ovw_load = mod_wr && ctrl.ovw;
  assign flag_clr = (ctrl_wr && bus_wdata[B_FLAG]) || mod_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl <= '0;
    else if (ctrl_wr) ctrl <= new_ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      period <= {CNT_W{1'b1}};
    else if (mod_wr) period <= bus_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag <= 1'b0;
    else if (underflow) flag <= 1'b1;
    else if (flag_clr)  flag <= 1'b0;
  end

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> flag);

  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ctrl_wr && !mod_wr) |=> flag);

  p_flag_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[B_FLAG] && !underflow) |=> !flag);

  p_flag_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && ctrl_wr && !bus_wdata[B_FLAG]) |=> flag);

  p_mod_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_wr && !underflow) |=> !flag);

endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);

  ctrl_t            ctrl;
  logic             flag;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] count;
  logic             restart;
  logic             ovw_load;
  logic             tick;
  logic             underflow;

  intv_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .underflow (underflow),
    .ctrl      (ctrl),
    .flag      (flag),
    .period    (period),
    .restart   (restart),
    .ovw_load  (ovw_load)
  );

  intv_prescaler u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl.en),
    .restart (restart),
    .pre     (ctrl.pre),
    .tick    (tick)
  );

  intv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rld       (ctrl.rld),
    .period    (period),
    .load      (ovw_load),
    .load_val  (bus_wdata[CNT_W-1:0]),
    .count     (count),
    .underflow (underflow)
  );

  always_comb begin
    unique case (bus_addr)
      OFF_CTRL: bus_rdata = ctrl_to_word(ctrl, flag);
      OFF_MOD:  bus_rdata = DATA_W'(period);
      OFF_CNT:  bus_rdata = DATA_W'(count);
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_o = flag & ctrl.ie;

  p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CTRL && bus_wdata[B_FLAG] && !underflow) |=> !irq_o);

  p_irq_needs_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(underflow) || $past(bus_wr)));

endmodule

// File: tb/test_intv_timer.sv
module test_intv_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [2:0]  addr;
    logic [15:0] exp;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  intv_timer i_intv_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  // control word encodings used below
  localparam logic [15:0] EN = 16'h0001, RLD = 16'h0002, FLG = 16'h0004,
                          IE = 16'h0008, OVW = 16'h0010, DBG = 16'h0020,
                          DOZE = 16'h0040;

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] e, input string tag);
    exp_t it;
    @(negedge clk);
    bus_addr = a;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic irq_chk(input logic e, input string tag);
    exp_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.addr = 3'd0; it.exp = {15'd0, e}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares just after each falling edge
  initial begin
    exp_t e;
    logic [15:0] act;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        act = e.is_irq ? {15'd0, irq_o} : bus_rdata;
        total++;
        if (act !== e.exp) begin
          bad++;
          $display("FAIL %s %s addr=%0d actual=%h expected=%h",
                   e.tag, e.is_irq ? "irq" : "read", e.addr, act, e.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state, R2 decode
    rd_chk(3'd0, 16'h0000, "R1");
    rd_chk(3'd2, 16'hFFFF, "R1");
    rd_chk(3'd4, 16'hFFFF, "R1");
    irq_chk(1'b0, "R1");
    rd_chk(3'd6, 16'h0000, "R2");

    // R11 immediate load
    wr(3'd0, OVW);
    wr(3'd2, 16'd5);
    rd_chk(3'd4, 16'd5, "R11");
    rd_chk(3'd2, 16'd5, "R2");
    // R2 count write ignored
    wr(3'd4, 16'h1234);
    rd_chk(3'd4, 16'd5, "R2");
    // R3 hold while stopped
    idle(3);
    rd_chk(3'd4, 16'd5, "R3");

    // R3/R4 run, N=0, reload from period; write edge is m=0
    wr(3'd0, EN | RLD | OVW | IE);
    rd_chk(3'd4, 16'd5, "R3");                 // m=0
    rd_chk(3'd4, 16'd5, "R3");                 // m=1
    rd_chk(3'd4, 16'd4, "R3");                 // m=2
    idle(7);
    rd_chk(3'd4, 16'd0, "R3");                 // m=10
    rd_chk(3'd0, EN | RLD | OVW | IE, "R6");   // m=11
    rd_chk(3'd4, 16'd5, "R4");                 // m=12
    rd_chk(3'd0, EN | RLD | OVW | IE | FLG, "R6"); // m=13
    irq_chk(1'b1, "R8");                       // m=14
    idle(1);

    // R9 IE-only write at odd edge m=17
    wr(3'd0, EN | RLD | OVW);
    rd_chk(3'd4, 16'd3, "R9");                 // m=17
    rd_chk(3'd4, 16'd2, "R9");                 // m=18
    rd_chk(3'd0, EN | RLD | OVW | FLG, "R7");  // m=19
    irq_chk(1'b0, "R8");                       // m=20

    // R7 write-one-to-clear, edge m=22
    wr(3'd0, EN | RLD | OVW | FLG);
    rd_chk(3'd0, EN | RLD | OVW, "R7");        // m=22

    // R10 restart with N=1 at edge m=24 (underflow on same edge)
    wr(3'd0, 16'h0100 | EN | RLD | OVW);
    rd_chk(3'd4, 16'd5, "R10");                // m=24
    rd_chk(3'd0, 16'h0100 | EN | RLD | OVW | FLG, "R6"); // m=25
    idle(1);
    rd_chk(3'd4, 16'd5, "R10");                // m=27
    rd_chk(3'd4, 16'd4, "R3");                 // m=28

    // R5 free run, R11 no-overwrite period write, R12 dbg/doze
    wr(3'd0, DOZE | DBG | EN);                 // F0
    wr(3'd2, 16'd2);                           // F0+1
    rd_chk(3'd0, DOZE | DBG | EN, "R11");      // F0+1, flag cleared
    rd_chk(3'd4, 16'd3, "R12");                // F0+2
    idle(7);
    rd_chk(3'd4, 16'hFFFF, "R5");              // F0+10
    rd_chk(3'd0, DOZE | DBG | EN | FLG, "R5"); // F0+11
    rd_chk(3'd2, 16'd2, "R11");                // F0+12

    // R11 load beats tick; R3 hold after stop
    wr(3'd0, DOZE | DBG | OVW | EN);           // C
    rd_chk(3'd0, DOZE | DBG | OVW | EN | FLG, "R7");
    wr(3'd2, 16'h0010);                        // C+2, tick same edge
    rd_chk(3'd4, 16'h0010, "R11");
    rd_chk(3'd0, DOZE | DBG | OVW | EN, "R11");
    wr(3'd0, DOZE | DBG | OVW);                // C+5
    rd_chk(3'd4, 16'h000F, "R3");
    idle(4);
    rd_chk(3'd4, 16'h000F, "R3");

    idle(3);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule